// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 32 interrupt inputs and presents the most urgent one to a processor on an active-low request line. Each input has its own control word. The word selects how the input is sensed (low level, high level, falling edge or rising edge) and gives it a priority from 0 to 7. Two command words manage the enable set. A 1 written to one of them enables the matching inputs, and a 1 written to the other disables them. Two more command words let software force an input pending or clear it.

The processor services an interrupt in two steps. It first reads the vector word, which returns the winning input number times four. That read is the acknowledge: the request line goes high and stays high while the service is open. Later, any write to the end-of-service word closes the service, and the next pending input can then raise the request. Status words show the raw input levels, the pending set before and after enabling, and the number of the input in service. The register bus is a plain synchronous port with byte addresses. Read data is combinational from the address.

Top module: `vic32`

## Requirements
- R1: After reset every input is disabled (word 0x114 reads 0), every control word reads 0x40 (high level, priority 0), the request output `irq_n` is 1 and word 0x10C reads 0.
- R2: The control word of input n is at byte offset 4·n. Bits 7:6 give the sense: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. Bits 2:0 give the priority. All other bits read back as 0.
- R3: A write to 0x120 enables each input whose data bit is 1. A write to 0x124 disables each input whose data bit is 1. Zero bits leave the input as it was. Word 0x114 reads 1 for each enabled input.
- R4: A read of 0x10C with no service open returns 4·w, where w is the pending, enabled input with the highest priority. Priority 7 is the highest, and on equal priority the lower number wins. With nothing pending the read returns 0.
- R5: `irq_n` is 0 while an enabled input is pending and no service is open. The cycle after an acknowledging read of 0x10C, `irq_n` is 1, and it stays 1 until end of service.
- R6: A write of any data to 0x130 closes the service. From the next cycle a pending, enabled input drives `irq_n` low again.
- R7: A level-sensed input is pending exactly while its pin is at the selected level. It holds no pending state of its own.
- R8: An edge-sensed input latches pending on the selected edge. It stays pending after the pin returns, and the acknowledge that selects it clears the latch.
- R9: A write to 0x128 forces pending each input whose data bit is 1. A write to 0x12C clears the latched pending of each input whose data bit is 1. An acknowledge of a forced input clears it as well.
- R10: Word 0x100 reads the raw pins. Word 0x104 reads pending regardless of enable. Word 0x108 reads pending and enabled. Word 0x110 reads the number of the last acknowledged input.
- R11: A read of 0x10C while a service is open returns 4 × the number of the input in service and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Interrupt input pins |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume the pins are synchronous to `clk`, so a pending bit seen in one cycle is still valid when an acknowledge in that cycle checks its vector. The bench drives every bus access as a single strobe lasting one cycle, set up on the falling edge. It changes the pins only on the falling edge, and never between a status read and the acknowledge that follows it. Edge tests leave one clock between changes of a pin, so each edge is seen once.

// File: rtl/vic32.sv
module vic32 #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int AW   = 9,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] A_RAW = AW'('h100);
  localparam logic [AW-1:0] A_ACT = AW'('h104);
  localparam logic [AW-1:0] A_MSK = AW'('h108);
  localparam logic [AW-1:0] A_VEC = AW'('h10C);
  localparam logic [AW-1:0] A_CUR = AW'('h110);
  localparam logic [AW-1:0] A_ENR = AW'('h114);
  localparam logic [AW-1:0] A_ENS = AW'('h120);
  localparam logic [AW-1:0] A_DIS = AW'('h124);
  localparam logic [AW-1:0] A_SET = AW'('h128);
  localparam logic [AW-1:0] A_CLR = AW'('h12C);
  localparam logic [AW-1:0] A_EOS = AW'('h130);

  logic [1:0]      sense [NSRC];
  logic [PW-1:0]   prio  [NSRC];
  logic [NSRC-1:0] en, lat, src_d, lvl, edg, pend, mpend;
  logic            in_svc, any;
  logic [IW-1:0]   svc_id, win, cidx;
  logic [PW-1:0]   best;

  wire sel_ctl = bus_addr < AW'(NSRC * 4);
  assign cidx  = bus_addr[IW+1:2];
  wire ack     = bus_rd && bus_addr == A_VEC && any && !in_svc;
  wire wr_ens  = bus_wr && bus_addr == A_ENS;
  wire wr_dis  = bus_wr && bus_addr == A_DIS;
  wire wr_set  = bus_wr && bus_addr == A_SET;
  wire wr_clr  = bus_wr && bus_addr == A_CLR;
  wire wr_eos  = bus_wr && bus_addr == A_EOS;

  for (genvar i = 0; i < NSRC; i++) begin : g_sense
    assign lvl[i] = ~sense[i][1] & (src_in[i] ~^ sense[i][0]);
    assign edg[i] = sense[i][1] & (sense[i][0] ? (src_in[i] & ~src_d[i])
                                               : (~src_in[i] & src_d[i]));
  end

  assign pend  = lvl | lat;
  assign mpend = pend & en;
  assign irq_n = ~(any & ~in_svc);

  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (mpend[i] && (!any || prio[i] >= best)) begin
        any  = 1'b1;
        win  = IW'(i);
        best = prio[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        sense[i] <= 2'd1;
        prio[i]  <= '0;
      end
    end else if (bus_wr && sel_ctl) begin
      sense[cidx] <= bus_wdata[7:6];
      prio[cidx]  <= bus_wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= '0;
      lat    <= '0;
      src_d  <= '0;
      in_svc <= 1'b0;
      svc_id <= '0;
    end else begin
      src_d <= src_in;
      if (wr_ens) en <= en | bus_wdata[NSRC-1:0];
      if (wr_dis) en <= en & ~bus_wdata[NSRC-1:0];
      lat <= (lat | edg | (wr_set ? bus_wdata[NSRC-1:0] : '0))
             & ~(wr_clr ? bus_wdata[NSRC-1:0] : '0)
             & ~(ack ? (NSRC'(1) << win) : '0);
      if (ack) begin
        in_svc <= 1'b1;
        svc_id <= win;
      end else if (wr_eos) begin
        in_svc <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctl) begin
      bus_rdata[7:6]    = sense[cidx];
      bus_rdata[PW-1:0] = prio[cidx];
    end else begin
      case (bus_addr)
        A_RAW: bus_rdata = DW'(src_in);
        A_ACT: bus_rdata = DW'(pend);
        A_MSK: bus_rdata = DW'(mpend);
        A_VEC: bus_rdata = in_svc ? DW'({svc_id, 2'b00}) : (any ? DW'({win, 2'b00}) : '0);
        A_CUR: bus_rdata = DW'(svc_id);
        A_ENR: bus_rdata = DW'(en);
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r4_vector_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (bus_rdata[1:0] == 2'b00 && mpend[bus_rdata[IW+1:2]]));
  a_r5_ack_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> irq_n);
  a_r5_held_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc && !wr_eos) |=> irq_n);
  a_r6_eos_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eos && !ack) |=> !in_svc);
  a_r3_disable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> (en & $past(bus_wdata[NSRC-1:0])) == '0);
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (lat & $past(bus_wdata[NSRC-1:0])) == '0);
endmodule

// File: tb/vic32_test.sv
module vic32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;
  int checks = 0, errors = 0;
  logic [31:0] en_m = '0;

  vic32 uut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
             .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); src_in = v;
    @(negedge clk);
  endtask

  function automatic int prio_of(input int i);
    return (i * 5 + 3) % 8;
  endfunction

  function automatic int winner(input logic [31:0] m);
    int w = -1;
    for (int i = 0; i < 32; i++)
      if (m[i] && (w < 0 || prio_of(i) > prio_of(w))) w = i;
    return w;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, pat, exp_m;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(9'h114, r); chk("R1 enables", r, 32'h0);
    chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
    rd(9'h10C, r); chk("R1 vector", r, 32'h0);
    for (int i = 0; i < 32; i++) begin
      rd(9'(i * 4), r); chk("R1 ctrl", r, 32'h40);
    end

    for (int i = 0; i < 32; i++)
      wr(9'(i * 4), {24'hFFFFFF, 2'(i % 4), 3'b111, 3'(i % 8)});
    for (int i = 0; i < 32; i++) begin
      rd(9'(i * 4), r); chk("R2 ctrl", r, {24'h0, 2'(i % 4), 3'b000, 3'(i % 8)});
    end
    for (int i = 0; i < 32; i++) wr(9'(i * 4), 32'h40 | 32'(prio_of(i)));

    wr(9'h120, 32'hA5A5A5A5); wr(9'h124, 32'h0000FFFF);
    rd(9'h114, r); chk("R3 enables", r, 32'hA5A50000);
    wr(9'h120, 32'h00000000);
    rd(9'h114, r); chk("R3 zero write", r, 32'hA5A50000);
    wr(9'h120, 32'hFFFFFFFF); en_m = 32'hFFFFFFFF;

    for (int n = 0; n < 32; n++) begin
      drive(32'(1) << n);
      chk("R5 irq low", {31'b0, irq_n}, 32'h0);
      rd(9'h10C, r); chk("R4 single", r, 32'(n * 4));
      chk("R5 irq high after ack", {31'b0, irq_n}, 32'h1);
      rd(9'h110, r); chk("R10 in service", r, 32'(n));
      wr(9'h130, 32'h0);
      chk("R6 reassert", {31'b0, irq_n}, 32'h0);
    end

    pat = 32'h1234ABCD;
    for (int k = 0; k < 60; k++) begin
      pat = pat ^ (pat << 13); pat = pat ^ (pat >> 17); pat = pat ^ (pat << 5);
      if (k == 20) begin wr(9'h124, 32'h0F0F0F0F); en_m = 32'hF0F0F0F0; end
      if (k == 40) begin wr(9'h120, 32'h0F0F0F0F); en_m = 32'hFFFFFFFF; end
      drive(k % 10 == 9 ? 32'h0 : pat & (k[0] ? 32'h00FF00FF : 32'hFFFFFFFF));
      rd(9'h100, r); chk("R10 raw", r, src_in);
      rd(9'h104, r); chk("R10 active", r, src_in);
      exp_m = src_in & en_m;
      rd(9'h108, r); chk("R10 masked", r, exp_m);
      w = winner(exp_m);
      if (w < 0) begin
        chk("R5 idle irq", {31'b0, irq_n}, 32'h1);
        rd(9'h10C, r); chk("R4 empty", r, 32'h0);
      end else begin
        rd(9'h10C, r); chk("R4 priority", r, 32'(w * 4));
        rd(9'h10C, r); chk("R11 repeat read", r, 32'(w * 4));
        rd(9'h108, r); chk("R11 no change", r, exp_m);
        chk("R5 held", {31'b0, irq_n}, 32'h1);
        wr(9'h130, 32'hDEADBEEF);
        rd(9'h110, r); chk("R10 last id", r, 32'(w));
      end
    end

    drive(32'h0);
    wr(9'h0C, 32'h02);
    rd(9'h104, r); chk("R7 low level active", r, 32'h8);
    drive(32'h8);
    rd(9'h104, r); chk("R7 low level released", r, 32'h0);
    wr(9'h0C, 32'h40 | 32'(prio_of(3)));

    drive(32'h0);
    wr(9'h14, 32'hC7); wr(9'h18, 32'h87);
    drive(32'h20); drive(32'h0);
    rd(9'h104, r); chk("R8 rising latched", r, 32'h20);
    rd(9'h10C, r); chk("R8 rising vector", r, 32'd20);
    rd(9'h104, r); chk("R8 ack clears", r, 32'h0);
    wr(9'h130, 32'h0);
    drive(32'h40);
    rd(9'h104, r); chk("R8 falling not on rise", r, 32'h0);
    drive(32'h0);
    rd(9'h104, r); chk("R8 falling latched", r, 32'h40);
    wr(9'h12C, 32'h40);
    rd(9'h104, r); chk("R9 clear edge", r, 32'h0);

    wr(9'h128, 32'h200);
    rd(9'h104, r); chk("R9 forced", r, 32'h200);
    wr(9'h12C, 32'h200);
    rd(9'h104, r); chk("R9 cleared", r, 32'h0);
    chk("R9 irq idle", {31'b0, irq_n}, 32'h1);
    wr(9'h128, 32'h200);
    rd(9'h10C, r); chk("R9 forced vector", r, 32'd36);
    rd(9'h104, r); chk("R9 ack clears forced", r, 32'h0);
    wr(9'h130, 32'h0);
    chk("R6 idle after eos", {31'b0, irq_n}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule